// File: doc/BRIEF.md
# Two-Layer Display Mode Compositor

This block merges a primary and a secondary pixel stream into one output pixel for each raster position. An external timing generator supplies the raster coordinate and a data-enable. Each layer comes with a valid flag, an 8-bit alpha value and a start corner. A layer covers everything to the right of and below its start corner. A 3-bit mode code chooses one of three views: the constant background colour alone, the primary layer alone, or the secondary layer drawn over the primary.

Two control words are held in parallel. The normal word is used during ordinary operation. The safe word is used while the fallback input is high, so the whole picture can be switched to a known view, such as flat colour, in a single cycle. Each control word also has its own per-layer alpha enables.

Pixels are 30 bits wide, with three 10-bit channels. The result is registered, so the output appears one cycle after its inputs, aligned with the delayed data-enable.

Top module: `layer_compositor`

## Requirements
- R1: `out_de` equals `de_in` delayed by one clock. `out_pix` is zero whenever `out_de` is low. Reset (synchronous, active low) clears both.
- R2: In a control word, bits 2:0 are the mode, bit 3 enables primary alpha and bit 4 enables secondary alpha. While `fallback` is high, `safe_ctl` is used in place of `mode_ctl`.
- R3: Mode 1 outputs `bg_color`, whatever the layer inputs are.
- R4: Pixels and `bg_color` are red in bits 29:20, green in bits 19:10 and blue in bits 9:0. Blending is done on each channel separately.
- R5: An area word holds start Y plus one in bits 29:16 and start X plus one in bits 13:0. A layer covers a position when x >= start X and y >= start Y. An encoded value of 0 covers the whole raster.
- R6: A layer takes part only when its valid flag is high and it covers the position.
- R7: In mode 5, a participating secondary pixel with its alpha disabled replaces whatever lies below it.
- R8: Where the secondary layer does not participate, the lower result is shown. The lower result is the primary pixel if the primary participates, and otherwise `bg_color`.
- R9: With alpha enabled, a channel becomes (top·a + below·(255−a) + 127) / 255, rounded down. The primary layer blends over `bg_color`; the secondary blends over the lower result.
- R10: Mode codes other than 1 and 5 show the lower result only. The secondary inputs have no effect.
- R11: With a layer's alpha bit clear, its alpha input has no effect and the layer is opaque.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| de_in | input | 1 | Data-enable from the timing generator |
| pos_x | input | 14 | Raster column |
| pos_y | input | 14 | Raster row |
| fallback | input | 1 | Selects `safe_ctl` instead of `mode_ctl` |
| mode_ctl | input | 5 | Normal control word |
| safe_ctl | input | 5 | Fallback control word |
| bg_color | input | 30 | Constant background colour |
| pri_area | input | 30 | Primary start corner, +1 encoded |
| pri_valid | input | 1 | Primary pixel valid |
| pri_pix | input | 30 | Primary pixel |
| pri_alpha | input | 8 | Primary alpha |
| sec_area | input | 30 | Secondary start corner, +1 encoded |
| sec_valid | input | 1 | Secondary pixel valid |
| sec_pix | input | 30 | Secondary pixel |
| sec_alpha | input | 8 | Secondary alpha |
| out_de | output | 1 | Delayed data-enable |
| out_pix | output | 30 | Composited pixel |

## Verification
The table drives the three modes with both layers present, with each layer missing, and with neither present. This separates "secondary wins", "primary wins" and "background shows" from one another. Start corners one step to either side of the raster position, and exactly on it, test the +1 encoding in both axes.

Alpha values of 0, 255 and two in-between values are used with distinct channel values. This exposes swapped operands, swapped channels and wrong rounding. Alpha is also tried with its enable bit clear, to show that the alpha input is ignored. The fallback input is toggled against differing normal and safe words, to show which word governs the output.

// File: rtl/comp_pkg.sv
// Shared constants and types for the layer compositor.
// Assumes three colour channels per pixel.
package comp_pkg;
    localparam int CH_W    = 10;
    localparam int ALPHA_W = 8;
    localparam int COORD_W = 14;
    localparam int Y_LSB   = 16;
    localparam int MODE_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        VIEW_PRI     = 3'd0,
        VIEW_BG      = 3'd1,
        VIEW_SEC_TOP = 3'd5
    } view_e;

    // Control word: alpha enables above the mode field.
    typedef struct packed {
        logic              sec_alpha_en;
        logic              pri_alpha_en;
        logic [MODE_W-1:0] view;
    } ctl_t;
endpackage

// File: rtl/area_hit.sv
// Decides whether a raster position lies inside a layer area.
// The area word stores start Y and start X, each as coordinate + 1.
// An encoded 0 in an axis covers that whole axis.
module area_hit #(
    parameter int COORD_W = 14,
    parameter int Y_LSB   = 16,
    localparam int AREA_W = Y_LSB + COORD_W
) (
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] pos_y,
    input  logic [AREA_W-1:0]  area,
    output logic               hit
);
    logic [COORD_W:0] x_p1, y_p1, ex, ey;

    // Compare position + 1 with the encoded start, so that no subtraction can wrap.
    always_comb begin
        x_p1 = {1'b0, pos_x} + 1'b1;
        y_p1 = {1'b0, pos_y} + 1'b1;
        ex   = {1'b0, area[COORD_W-1:0]};
        ey   = {1'b0, area[Y_LSB +: COORD_W]};
        hit  = (x_p1 >= ex) && (y_p1 >= ey);
    end
endmodule

// File: rtl/px_blend.sv
// Per-channel alpha mix: (top*a + bot*(max-a) + max/2) / max.
// Assumes the channels are packed with the most significant channel first.
module px_blend #(
    parameter int CH_W    = 10,
    parameter int ALPHA_W = 8,
    parameter int N_CH    = 3,
    localparam int PIX_W  = CH_W * N_CH
) (
    input  logic [PIX_W-1:0]   top,
    input  logic [PIX_W-1:0]   bot,
    input  logic [ALPHA_W-1:0] alpha,
    output logic [PIX_W-1:0]   mix
);
    localparam int SUM_W = CH_W + ALPHA_W + 1;
    localparam logic [SUM_W-1:0] A_MAX = SUM_W'((1 << ALPHA_W) - 1);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [SUM_W-1:0] sum, quo;

        // Weighted sum with half-step rounding, then scale back to channel width.
        always_comb begin
            sum = SUM_W'(top[c*CH_W +: CH_W]) * SUM_W'(alpha)
                + SUM_W'(bot[c*CH_W +: CH_W]) * (A_MAX - SUM_W'(alpha))
                + (A_MAX >> 1);
            quo = sum / A_MAX;
            mix[c*CH_W +: CH_W] = quo[CH_W-1:0];
        end
    end
endmodule

// File: rtl/layer_compositor.sv
// Two-layer compositor: chooses a control word (normal or fallback),
// resolves the layer coverage, builds primary-over-background, and then,
// in secondary-on-top mode, puts the secondary over that result.
// Assumes the raster position and data-enable come from an external
// timing generator, and that layer pixels arrive aligned with them.
// The output is registered, with one cycle of latency.
module layer_compositor
    import comp_pkg::*;
#(
    parameter int CW = comp_pkg::CH_W,
    parameter int AW = comp_pkg::ALPHA_W,
    parameter int XW = comp_pkg::COORD_W,
    localparam int PW = 3 * CW,
    localparam int RW = comp_pkg::Y_LSB + XW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          de_in,
    input  logic [XW-1:0] pos_x,
    input  logic [XW-1:0] pos_y,
    input  logic          fallback,
    input  logic [4:0]    mode_ctl,
    input  logic [4:0]    safe_ctl,
    input  logic [PW-1:0] bg_color,
    input  logic [RW-1:0] pri_area,
    input  logic          pri_valid,
    input  logic [PW-1:0] pri_pix,
    input  logic [AW-1:0] pri_alpha,
    input  logic [RW-1:0] sec_area,
    input  logic          sec_valid,
    input  logic [PW-1:0] sec_pix,
    input  logic [AW-1:0] sec_alpha,
    output logic          out_de,
    output logic [PW-1:0] out_pix
);
    ctl_t          ctl;
    logic          pri_in, sec_in, pri_on, sec_on;
    logic [PW-1:0] pri_mix, sec_mix, lower, upper, result;

    // Pick the control word that is in force.
    always_comb ctl = fallback ? ctl_t'(safe_ctl) : ctl_t'(mode_ctl);

    area_hit #(.COORD_W(XW), .Y_LSB(comp_pkg::Y_LSB)) i_pri_hit (
        .pos_x(pos_x), .pos_y(pos_y), .area(pri_area), .hit(pri_in));
    area_hit #(.COORD_W(XW), .Y_LSB(comp_pkg::Y_LSB)) i_sec_hit (
        .pos_x(pos_x), .pos_y(pos_y), .area(sec_area), .hit(sec_in));

    px_blend #(.CH_W(CW), .ALPHA_W(AW), .N_CH(3)) i_pri_mix (
        .top(pri_pix), .bot(bg_color), .alpha(pri_alpha), .mix(pri_mix));
    px_blend #(.CH_W(CW), .ALPHA_W(AW), .N_CH(3)) i_sec_mix (
        .top(sec_pix), .bot(lower), .alpha(sec_alpha), .mix(sec_mix));

    // Layer participation, then stacking: primary over background, secondary over that.
    always_comb begin
        pri_on = pri_valid && pri_in;
        sec_on = sec_valid && sec_in;
        lower  = !pri_on ? bg_color : (ctl.pri_alpha_en ? pri_mix : pri_pix);
        upper  = !sec_on ? lower    : (ctl.sec_alpha_en ? sec_mix : sec_pix);
        case (ctl.view)
            VIEW_BG:      result = bg_color;
            VIEW_SEC_TOP: result = upper;
            default:      result = lower;
        endcase
    end

    // Output register; the pixel is forced to zero outside active video.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_de  <= 1'b0;
            out_pix <= '0;
        end else begin
            out_de  <= de_in;
            out_pix <= de_in ? result : '0;
        end
    end
endmodule

// File: rtl/layer_compositor_chk.sv
// Property checker for layer_compositor, attached with bind.
// Assumes the default 14-bit coordinates and 10-bit channels.
module layer_compositor_chk #(
    parameter int PW = 30,
    parameter int RW = 30
) (
    input logic          clk,
    input logic          rst_n,
    input logic          de_in,
    input logic          fallback,
    input logic [4:0]    mode_ctl,
    input logic [4:0]    safe_ctl,
    input logic [PW-1:0] bg_color,
    input logic          pri_valid,
    input logic          sec_valid,
    input logic [RW-1:0] sec_area,
    input logic [PW-1:0] sec_pix,
    input logic          out_de,
    input logic [PW-1:0] out_pix
);
    logic       live;
    logic [4:0] ctl_now;

    // Becomes true once one clock has passed out of reset, so $past is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // Control word seen by the checker.
    always_comb ctl_now = fallback ? safe_ctl : mode_ctl;

    AST_DE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> out_de == $past(de_in)); // R1
    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_de |-> out_pix == '0); // R1
    AST_BG_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(de_in && ctl_now[2:0] == 3'd1) |-> out_pix == $past(bg_color)); // R3
    AST_SAFE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(de_in && fallback && safe_ctl[2:0] == 3'd1) |-> out_pix == $past(bg_color)); // R2
    AST_SEC_OPAQUE: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(de_in && ctl_now[2:0] == 3'd5 && !ctl_now[4] && sec_valid && sec_area == '0)
        |-> out_pix == $past(sec_pix)); // R7
    AST_EMPTY_BG: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(de_in && !pri_valid && !sec_valid) |-> out_pix == $past(bg_color)); // R8
endmodule

bind layer_compositor layer_compositor_chk #(.PW(PW), .RW(RW)) i_chk (
    .clk(clk), .rst_n(rst_n), .de_in(de_in), .fallback(fallback),
    .mode_ctl(mode_ctl), .safe_ctl(safe_ctl), .bg_color(bg_color),
    .pri_valid(pri_valid), .sec_valid(sec_valid), .sec_area(sec_area),
    .sec_pix(sec_pix), .out_de(out_de), .out_pix(out_pix));

// File: tb/test_layer_compositor.sv
// Table-driven bench for layer_compositor, followed by directed reset and blanking tests.
module test_layer_compositor;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    localparam logic [29:0] BG = {10'd100, 10'd200, 10'd300};
    localparam logic [29:0] PP = {10'd400, 10'd500, 10'd600};
    localparam logic [29:0] SP = {10'd10,  10'd20,  10'd30};

    // Area word for a start corner (x, y), with +1 encoding.
    function automatic logic [29:0] corner(int x, int y);
        logic [13:0] ex, ey;
        ex = 14'(x + 1);
        ey = 14'(y + 1);
        return {ey, 2'b00, ex};
    endfunction

    typedef struct packed {
        logic [7:0]  req;
        logic [4:0]  mctl;
        logic [4:0]  sctl;
        logic        fb;
        logic        pv;
        logic        sv;
        logic [29:0] parea;
        logic [29:0] sarea;
        logic [7:0]  pa;
        logic [7:0]  sa;
        logic [29:0] exp;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TABLE [NV] = '{
        '{8'd10, 5'd0,  5'd0, 1'b0, 1'b1, 1'b1, 30'd0, 30'd0, 8'd0,   8'd0,   PP}, // R10 secondary ignored
        '{8'd3,  5'd1,  5'd0, 1'b0, 1'b1, 1'b1, 30'd0, 30'd0, 8'd0,   8'd0,   BG}, // R3
        '{8'd7,  5'd5,  5'd0, 1'b0, 1'b1, 1'b1, 30'd0, 30'd0, 8'd0,   8'd0,   SP}, // R7
        '{8'd6,  5'd5,  5'd0, 1'b0, 1'b1, 1'b0, 30'd0, 30'd0, 8'd0,   8'd0,   PP}, // R6 R8
        '{8'd8,  5'd5,  5'd0, 1'b0, 1'b0, 1'b0, 30'd0, 30'd0, 8'd0,   8'd0,   BG}, // R8
        '{8'd5,  5'd5,  5'd0, 1'b0, 1'b1, 1'b1, 30'd0, corner(6,5), 8'd0, 8'd0, PP}, // R5 x past
        '{8'd5,  5'd5,  5'd0, 1'b0, 1'b1, 1'b1, 30'd0, corner(5,5), 8'd0, 8'd0, SP}, // R5 on corner
        '{8'd5,  5'd5,  5'd0, 1'b0, 1'b1, 1'b1, 30'd0, corner(5,6), 8'd0, 8'd0, PP}, // R5 y past
        '{8'd6,  5'd5,  5'd0, 1'b0, 1'b1, 1'b1, corner(9,9), 30'd0, 8'd0, 8'd0, SP}, // R6 primary outside
        '{8'd6,  5'd0,  5'd0, 1'b0, 1'b1, 1'b0, corner(9,9), 30'd0, 8'd0, 8'd0, BG}, // R6 R8
        '{8'd9,  5'd21, 5'd0, 1'b0, 1'b1, 1'b1, 30'd0, 30'd0, 8'd0,   8'd255, SP}, // R9 a=255
        '{8'd9,  5'd21, 5'd0, 1'b0, 1'b1, 1'b1, 30'd0, 30'd0, 8'd0,   8'd0,   PP}, // R9 a=0
        '{8'd9,  5'd21, 5'd0, 1'b0, 1'b1, 1'b1, 30'd0, 30'd0, 8'd0,   8'd128,
          {10'd204, 10'd259, 10'd314}},                                            // R9 mid
        '{8'd11, 5'd5,  5'd0, 1'b0, 1'b1, 1'b1, 30'd0, 30'd0, 8'd0,   8'd0,   SP}, // R11
        '{8'd4,  5'd8,  5'd0, 1'b0, 1'b1, 1'b1, 30'd0, 30'd0, 8'd64,  8'd0,
          {10'd175, 10'd275, 10'd375}},                                            // R4 per channel
        '{8'd9,  5'd8,  5'd0, 1'b0, 1'b1, 1'b0, 30'd0, 30'd0, 8'd0,   8'd0,   BG}, // R9 primary a=0
        '{8'd11, 5'd0,  5'd0, 1'b0, 1'b1, 1'b0, 30'd0, 30'd0, 8'd0,   8'd0,   PP}, // R11 primary
        '{8'd2,  5'd5,  5'd1, 1'b1, 1'b1, 1'b1, 30'd0, 30'd0, 8'd0,   8'd0,   BG}, // R2 safe word
        '{8'd2,  5'd5,  5'd1, 1'b0, 1'b1, 1'b1, 30'd0, 30'd0, 8'd0,   8'd0,   SP}, // R2 normal word
        '{8'd2,  5'd1,  5'd0, 1'b1, 1'b1, 1'b1, 30'd0, 30'd0, 8'd0,   8'd0,   PP}  // R2 safe shows primary
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        de_in = 1'b0;
    logic [13:0] pos_x = 14'd5, pos_y = 14'd5;
    logic        fallback = 1'b0;
    logic [4:0]  mode_ctl = '0, safe_ctl = '0;
    logic [29:0] bg_color = BG;
    logic [29:0] pri_area = '0, sec_area = '0;
    logic        pri_valid = 1'b0, sec_valid = 1'b0;
    logic [29:0] pri_pix = PP, sec_pix = SP;
    logic [7:0]  pri_alpha = '0, sec_alpha = '0;
    logic        out_de;
    logic [29:0] out_pix;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    layer_compositor i_layer_compositor (
        .clk(clk), .rst_n(rst_n), .de_in(de_in), .pos_x(pos_x), .pos_y(pos_y),
        .fallback(fallback), .mode_ctl(mode_ctl), .safe_ctl(safe_ctl),
        .bg_color(bg_color), .pri_area(pri_area), .pri_valid(pri_valid),
        .pri_pix(pri_pix), .pri_alpha(pri_alpha), .sec_area(sec_area),
        .sec_valid(sec_valid), .sec_pix(sec_pix), .sec_alpha(sec_alpha),
        .out_de(out_de), .out_pix(out_pix));

    task automatic check(string req, logic [30:0] act, logic [30:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        de_in = 1'b1;
        pri_valid = 1'b1;
        sec_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", {out_de, out_pix}, 31'd0);

        rst_n = 1'b1;
        // Table walk: drive at a falling edge, sample one full cycle later.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            de_in = 1'b1;
            mode_ctl = TABLE[i].mctl;
            safe_ctl = TABLE[i].sctl;
            fallback = TABLE[i].fb;
            pri_valid = TABLE[i].pv;
            sec_valid = TABLE[i].sv;
            pri_area = TABLE[i].parea;
            sec_area = TABLE[i].sarea;
            pri_alpha = TABLE[i].pa;
            sec_alpha = TABLE[i].sa;
            @(negedge clk);
            check($sformatf("R%0d row %0d", TABLE[i].req, i),
                  {out_de, out_pix}, {1'b1, TABLE[i].exp});
        end

        // Blanking: de low gives zero pixel and low de one cycle later (R1).
        de_in = 1'b0;
        mode_ctl = 5'd5;
        fallback = 1'b0;
        pri_area = '0;
        sec_area = '0;
        @(negedge clk);
        check("R1 blank", {out_de, out_pix}, 31'd0);

        // Data-enable rises again: the pixel returns in the next cycle (R1).
        de_in = 1'b1;
        sec_valid = 1'b1;
        @(negedge clk);
        check("R1 de return", {out_de, out_pix}, {1'b1, SP});

        // Synchronous reset mid-stream clears the outputs (R1).
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 sync reset", {out_de, out_pix}, 31'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {out_de, out_pix}, {1'b1, SP});

        finish_run();
    end
endmodule